// File: doc/BRIEF.md
# Dual-Port Pixel Demultiplexer

This block takes one pixel sample on every clock, together with a horizontal sync input. It deals the samples out to two output ports, A and B, in alternation. Each port can then run at half the incoming pixel rate. The alternation restarts at every leading edge of the sync input, so the first sample of each line always lands on a known port. A swap bit chooses whether that port is A or B.

A mode bit chooses between two behaviours. In dual-port mode the samples alternate between the ports. In single-port mode every sample goes to port A. Both control bits are captured only at line start, so software or upstream logic may change them at any time without disturbing the line in progress. Each port has a data bus and a one-cycle valid strobe. A port's data bus keeps its last value between updates.

Top module: `pxdmx_demux`

## Requirements
- R1: A synchronous active-high reset clears both valid strobes, both data buses and the sample parity. Until the first sync leading edge after reset, the block behaves as in single-port mode, sending every sample to port A whatever the control inputs are.
- R2: The sync input is sampled on the clock. A leading edge is a clock edge at which the sync input is 1 and was 0 at the previous clock edge. The pixel sampled at that same clock edge is sample 1 of the line. Each port's data and valid are registered and change at the clock edge that samples the pixel.
- R3: In dual-port mode (dual input 1 at line start) with swap 0, sample 1 and every later odd-numbered sample go to port A. Every even-numbered sample goes to port B.
- R4: In dual-port mode with swap 1 the assignment is reversed. Sample 1 and every odd-numbered sample go to port B, and every even-numbered sample goes to port A.
- R5: In single-port mode (dual input 0 at line start), every sample goes to port A and port B's valid stays 0. The swap input has no effect in this mode.
- R6: The dual and swap inputs are taken only at a sync leading edge. A change in either input during a line has no effect until the next leading edge.
- R7: After reset, exactly one port takes each sample. On the cycle it takes the sample, that port's valid is 1 for one cycle and its data equals the sample. A port that does not take a sample keeps its data unchanged.
- R8: Every leading edge restarts the count at sample 1, even after a line with an odd number of samples. Holding the sync input high over several clocks does not restart the count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, active high |
| pix_in | input | W | Incoming pixel sample |
| cfg_dual | input | 1 | 1 selects dual-port mode, 0 selects single-port mode |
| cfg_swap | input | 1 | 1 sends the first sample of a line to port B |
| a_data | output | W | Port A sample, held between updates |
| a_vld | output | 1 | Port A took a new sample this cycle |
| b_data | output | W | Port B sample, held between updates |
| b_vld | output | 1 | Port B took a new sample this cycle |

## Verification
A wrong parity bit shows at the ports on the very next sample as a valid strobe on the wrong port. The error then persists to the end of the line, and the bench compares every cycle, so it is caught within one clock. A corrupt latched line configuration shows in the same cycle. It appears either as port B strobing in single-port mode or as the first sample of a line reaching the wrong port. The tests change the mode bits mid-line and use odd-length lines, so a latch that follows the live inputs, or a parity that fails to restart, diverges from the expected routing within one or two samples.

// File: rtl/pxdmx_pkg.sv
package pxdmx_pkg;

    typedef enum logic {
        PORT_A = 1'b0,
        PORT_B = 1'b1
    } port_e;

    localparam int unsigned NUM_PORTS = 2;

    typedef struct packed {
        logic dual;
        logic swap;
    } line_cfg_t;

    // Port that receives a sample, given the line setup and whether the
    // sample index within the line is odd.
    function automatic port_e pick_port(line_cfg_t c, logic odd);
        if (!c.dual) begin
            return PORT_A;
        end
        return (odd ^ c.swap) ? PORT_A : PORT_B;
    endfunction

endpackage

// File: rtl/pxdmx_edge.sv
module pxdmx_edge (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    output logic line_start
);
    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q <= 1'b0;
        end else begin
            hs_q <= hsync_in;
        end
    end

    assign line_start = hsync_in & ~hs_q;
endmodule

// File: rtl/pxdmx_line_ctl.sv
module pxdmx_line_ctl
    import pxdmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  line_start,
    input  logic  cfg_dual,
    input  logic  cfg_swap,
    output port_e route
);
    line_cfg_t cfg_q;
    line_cfg_t cur_cfg;
    logic      next_odd_q;
    logic      cur_odd;

    always_comb begin
        cur_cfg = cfg_q;
        if (line_start) begin
            cur_cfg.dual = cfg_dual;
            cur_cfg.swap = cfg_swap;
        end
        cur_odd = line_start | next_odd_q;
        route   = pick_port(cur_cfg, cur_odd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= '0;
            next_odd_q <= 1'b0;
        end else begin
            cfg_q      <= cur_cfg;
            next_odd_q <= ~cur_odd;
        end
    end
endmodule

// File: rtl/pxdmx_port_reg.sv
module pxdmx_port_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         take,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         vld
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= '0;
            vld  <= 1'b0;
        end else begin
            vld <= take;
            if (take) begin
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/pxdmx_demux.sv
module pxdmx_demux
    import pxdmx_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hsync_in,
    input  logic [W-1:0] pix_in,
    input  logic         cfg_dual,
    input  logic         cfg_swap,
    output logic [W-1:0] a_data,
    output logic         a_vld,
    output logic [W-1:0] b_data,
    output logic         b_vld
);
    logic   line_start;
    port_e  route;
    logic [W-1:0] p_data [NUM_PORTS];
    logic         p_vld  [NUM_PORTS];

    pxdmx_edge edge_i (
        .clk        (clk),
        .rst        (rst),
        .hsync_in   (hsync_in),
        .line_start (line_start)
    );

    pxdmx_line_ctl ctl_i (
        .clk        (clk),
        .rst        (rst),
        .line_start (line_start),
        .cfg_dual   (cfg_dual),
        .cfg_swap   (cfg_swap),
        .route      (route)
    );

    for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
        pxdmx_port_reg #(.W(W)) reg_i (
            .clk  (clk),
            .rst  (rst),
            .take (route == port_e'(gp)),
            .din  (pix_in),
            .dout (p_data[gp]),
            .vld  (p_vld[gp])
        );
    end

    assign a_data = p_data[PORT_A];
    assign a_vld  = p_vld[PORT_A];
    assign b_data = p_data[PORT_B];
    assign b_vld  = p_vld[PORT_B];
endmodule

// File: rtl/pxdmx_checker.sv
module pxdmx_checker #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         hsync_in,
    input logic [W-1:0] pix_in,
    input logic         cfg_dual,
    input logic         cfg_swap,
    input logic [W-1:0] a_data,
    input logic         a_vld,
    input logic [W-1:0] b_data,
    input logic         b_vld
);
    logic seen;
    logic hs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen <= 1'b0;
            hs_q <= 1'b0;
        end else begin
            seen <= 1'b1;
            hs_q <= hsync_in;
        end
    end

    a_r7_one_port: assert property (@(posedge clk) disable iff (rst)
        seen |-> (a_vld ^ b_vld));

    a_r7_data_a: assert property (@(posedge clk) disable iff (rst)
        a_vld |-> (a_data == $past(pix_in)));

    a_r7_hold_b: assert property (@(posedge clk) disable iff (rst)
        (seen && !b_vld) |-> $stable(b_data));

    a_r3_first_a: assert property (@(posedge clk) disable iff (rst)
        (hsync_in && !hs_q && cfg_dual && !cfg_swap) |=> a_vld);

    a_r4_first_b: assert property (@(posedge clk) disable iff (rst)
        (hsync_in && !hs_q && cfg_dual && cfg_swap) |=> b_vld);

    a_r5_single_start: assert property (@(posedge clk) disable iff (rst)
        (hsync_in && !hs_q && !cfg_dual) |=> (a_vld && !b_vld));
endmodule

bind pxdmx_demux pxdmx_checker #(.W(W)) chk_i (.*);

// File: tb/pxdmx_demux_tb.sv
`timescale 1ns/1ps
module pxdmx_demux_tb_top;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hsync_in = 1'b0;
    logic [W-1:0] pix_in = '0;
    logic         cfg_dual = 1'b0;
    logic         cfg_swap = 1'b0;
    logic [W-1:0] a_data, b_data;
    logic         a_vld, b_vld;

    int checks = 0;
    int errors = 0;

    // reference state, derived from the requirements
    logic         m_hs, m_dual, m_swap, m_next_odd;
    logic [W-1:0] e_a, e_b;
    logic [W-1:0] pv = 8'h10;

    always #2.5 clk = ~clk;

    pxdmx_demux #(.W(W)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic hs, input logic dual, input logic swp, input string req);
        logic edge_now, odd, to_a;
        @(negedge clk);
        pv++;
        hsync_in = hs; pix_in = pv; cfg_dual = dual; cfg_swap = swp;
        edge_now = hs && !m_hs;
        m_hs = hs;
        if (edge_now) begin m_dual = dual; m_swap = swp; end
        odd = edge_now || m_next_odd;
        m_next_odd = !odd;
        to_a = !m_dual || (odd != m_swap);
        if (to_a) e_a = pv; else e_b = pv;
        @(posedge clk); #1;
        chk(req, a_vld, to_a);
        chk(req, b_vld, !to_a);
        chk(req, a_data, e_a);
        chk(req, b_data, e_b);
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst = 1'b1; hsync_in = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R1", a_vld, 0); chk("R1", b_vld, 0);
        chk("R1", a_data, 0); chk("R1", b_data, 0);
        m_hs = 0; m_dual = 0; m_swap = 0; m_next_odd = 0; e_a = '0; e_b = '0;
        @(negedge clk); rst = 1'b0;
        // before any leading edge: single-port despite dual requested (R1)
        for (int i = 0; i < 3; i++) step(0, 1, 0, "R1");
    endtask

    task automatic t_dual_phase0();
        step(1, 1, 0, "R2");              // sample 1 -> A
        for (int i = 0; i < 3; i++) step(1, 1, 0, "R8"); // held high, no restart
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R3");
    endtask

    task automatic t_dual_phase1();
        step(1, 1, 1, "R4");
        for (int i = 0; i < 6; i++) step(0, 1, 1, "R4");
    endtask

    task automatic t_single();
        step(1, 0, 1, "R5");
        for (int i = 0; i < 5; i++) step(0, 0, 1, "R5");
    endtask

    task automatic t_midline();
        step(1, 1, 0, "R6");
        step(0, 1, 1, "R6");
        step(0, 0, 1, "R6");
        step(0, 0, 0, "R6");
        step(0, 1, 1, "R6");
        step(1, 0, 0, "R6");             // new line picks single mode
        step(0, 1, 1, "R6");
        step(0, 1, 1, "R6");
    endtask

    task automatic t_restart();
        step(0, 1, 0, "R8");
        step(1, 1, 0, "R8");
        step(0, 1, 0, "R8");
        step(0, 1, 0, "R8");             // odd-length line: 3 samples
        step(1, 1, 0, "R8");             // restart: sample 1 -> A again
        step(0, 1, 0, "R8");
        step(1, 1, 1, "R8");             // 2-sample line then swapped line
        step(0, 1, 1, "R7");
        step(0, 1, 1, "R7");
    endtask

    initial begin
        t_reset();
        t_dual_phase0();
        t_dual_phase1();
        t_single();
        t_midline();
        t_restart();
        t_reset();
        t_dual_phase1();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule